// File: doc/BRIEF.md
# Fully Associative Tagged Translation Buffer

This block caches page translations in a small fully associative table. Each entry holds a virtual page number tag, a physical page number and an address-space number. It also holds a global flag that makes the entry match in every address space, read and write enables for each of the four privilege modes, and fault-on-read and fault-on-write flags. A lookup presents a virtual page number and the current address-space number. In the same cycle it returns hit, the index of the matching entry and that entry's fields, taken combinationally from the registered table.

Refill logic writes new translations through the insert port, which takes a full virtual address and stores its page-number part. The victim is picked by a rotating pointer, with no usage tracking. Three invalidation commands keep the table coherent: clear everything, drop every entry not marked global, and drop whatever would hit for a given address and address space. One instance parameterised with 48 entries serves instruction fetch and another with 64 serves data accesses.

Top module: `tlb_fa`

## Requirements
- R1: A lookup hits only on an entry that is valid, whose tag equals the lookup page number, and which is either marked global or holds an address-space number equal to the lookup one; `lk_ent_asn` then shows the stored number.
- R2: An accepted insert writes the entry at the victim pointer, replacing any valid entry there. The pointer then moves up by one and wraps from ENTRIES-1 to 0.
- R3: An insert stores bits [VA_W-1:OFS_W] of `ins_va` as the tag and marks the entry valid. A later hit returns the stored physical page, global flag, enables and fault flags unchanged.
- R4: `fl_all` invalidates every entry and returns the victim pointer to 0.
- R5: `fl_nonglobal` invalidates every entry whose global flag is clear and leaves global entries valid.
- R6: `fl_addr` invalidates every entry that a lookup with page number `fl_va[VA_W-1:OFS_W]` and `fl_asn` would hit, global entries with that tag included. Other entries are untouched.
- R7: When several entries hit, the lowest index is reported and `lk_multi` is 1. With one hit or none, `lk_multi` is 0.
- R8: A flush overrides an insert in the same cycle, so the insert is dropped and the pointer holds. Among flushes, `fl_all` beats `fl_nonglobal`, which beats `fl_addr`.
- R9: After reset every entry is invalid and the pointer is 0. On a miss all lookup data outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asn | input | ASN_W | Current address-space number |
| lk_hit | output | 1 | Lookup matched an entry |
| lk_idx | output | IDX_W | Index of the lowest matching entry |
| lk_multi | output | 1 | More than one entry matched |
| lk_ppn | output | PPN_W | Physical page of the hit entry |
| lk_ent_asn | output | ASN_W | Stored address-space number of the hit entry |
| lk_global | output | 1 | Global flag of the hit entry |
| lk_rd_en | output | 4 | Read enable per mode (bit = mode number) |
| lk_wr_en | output | 4 | Write enable per mode |
| lk_fault_rd | output | 1 | Fault-on-read flag |
| lk_fault_wr | output | 1 | Fault-on-write flag |
| ins_en | input | 1 | Insert request |
| ins_va | input | VA_W | Virtual address of the new mapping |
| ins_ppn | input | PPN_W | Physical page to store |
| ins_asn | input | ASN_W | Address-space number to store |
| ins_global | input | 1 | Global flag to store |
| ins_rd_en | input | 4 | Read enables to store |
| ins_wr_en | input | 4 | Write enables to store |
| ins_fault_rd | input | 1 | Fault-on-read flag to store |
| ins_fault_wr | input | 1 | Fault-on-write flag to store |
| fl_all | input | 1 | Invalidate all entries |
| fl_nonglobal | input | 1 | Invalidate non-global entries |
| fl_addr | input | 1 | Invalidate entries matching fl_va / fl_asn |
| fl_va | input | VA_W | Address for the selective flush |
| fl_asn | input | ASN_W | Address space for the selective flush |

## Verification
On every cycle the assertions check several rules. A non-global hit must carry the lookup's address-space number. The victim pointer must stay in range and move by exactly one after each insert that goes through. No lookup may hit in the cycle after a full flush, and only global entries may hit after a non-global flush. No lookup may hit the flushed page and address space right after a selective flush, and a multi-hit flag may only appear together with a hit. The bench scenarios are needed to show the rest: which entry a given insert landed in, the pointer wrapping onto an older mapping, field values coming back unchanged, the lowest-index choice among duplicates, and which request wins when a flush and an insert arrive together.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // privilege modes; each enable vector bit is indexed by this number
    localparam int MODE_CNT = 4;

    typedef enum logic [1:0] {
        MODE_KERNEL = 2'd0,
        MODE_EXEC   = 2'd1,
        MODE_SUPER  = 2'd2,
        MODE_USER   = 2'd3
    } priv_mode_e;

    // command resolved for one cycle, highest priority first
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_CLR_ALL,
        OP_CLR_NONGLB,
        OP_CLR_ADDR,
        OP_INSERT
    } tlb_op_e;

    typedef struct packed {
        logic [MODE_CNT-1:0] rd_en;
        logic [MODE_CNT-1:0] wr_en;
        logic                fault_rd;
        logic                fault_wr;
    } perm_t;

    function automatic tlb_op_e resolve_op(input logic all, input logic nonglb,
                                           input logic addr, input logic ins);
        if (all)         return OP_CLR_ALL;
        else if (nonglb) return OP_CLR_NONGLB;
        else if (addr)   return OP_CLR_ADDR;
        else if (ins)    return OP_INSERT;
        return OP_IDLE;
    endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int ENTRIES = 48,
    parameter int VPN_W   = 30,
    parameter int ASN_W   = 8
) (
    input  logic [ENTRIES-1:0] vld_i,
    input  logic [ENTRIES-1:0] glb_i,
    input  logic [VPN_W-1:0]   tag_i [ENTRIES],
    input  logic [ASN_W-1:0]   asn_i [ENTRIES],
    input  logic [VPN_W-1:0]   key_vpn_i,
    input  logic [ASN_W-1:0]   key_asn_i,
    output logic [ENTRIES-1:0] hit_o
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic tag_eq;
        logic asn_ok;
        assign tag_eq   = (tag_i[g] == key_vpn_i);
        assign asn_ok   = glb_i[g] || (asn_i[g] == key_asn_i);
        assign hit_o[g] = vld_i[g] && tag_eq && asn_ok;
    end

endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
    parameter int ENTRIES = 48,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] hit_i,
    output logic               any_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic               multi_o
);

    logic [ENTRIES-1:0] rest;

    always_comb begin
        idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_i[i]) idx_o = IDX_W'(i);
        end
    end

    // clearing the lowest set bit leaves something only on a multiple match
    assign rest    = hit_i & (hit_i - ENTRIES'(1));
    assign any_o   = |hit_i;
    assign multi_o = |rest;

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 48,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic             clr_i,
    output logic [IDX_W-1:0] ptr_o
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (clr_i) begin
            ptr_d = '0;
        end else if (adv_i) begin
            if (ptr_q == LAST) ptr_d = '0;
            else               ptr_d = ptr_q + IDX_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr_o = ptr_q;

endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 48,
    parameter int VA_W    = 43,
    parameter int OFS_W   = 13,
    parameter int PPN_W   = 27,
    parameter int ASN_W   = 8,
    localparam int VPN_W  = VA_W - OFS_W,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [ASN_W-1:0] lk_asn,
    output logic             lk_hit,
    output logic [IDX_W-1:0] lk_idx,
    output logic             lk_multi,
    output logic [PPN_W-1:0] lk_ppn,
    output logic [ASN_W-1:0] lk_ent_asn,
    output logic             lk_global,
    output logic [3:0]       lk_rd_en,
    output logic [3:0]       lk_wr_en,
    output logic             lk_fault_rd,
    output logic             lk_fault_wr,
    input  logic             ins_en,
    input  logic [VA_W-1:0]  ins_va,
    input  logic [PPN_W-1:0] ins_ppn,
    input  logic [ASN_W-1:0] ins_asn,
    input  logic             ins_global,
    input  logic [3:0]       ins_rd_en,
    input  logic [3:0]       ins_wr_en,
    input  logic             ins_fault_rd,
    input  logic             ins_fault_wr,
    input  logic             fl_all,
    input  logic             fl_nonglobal,
    input  logic             fl_addr,
    input  logic [VA_W-1:0]  fl_va,
    input  logic [ASN_W-1:0] fl_asn
);

    // payload of one entry; valid and global bits live in the control struct
    typedef struct packed {
        logic [VPN_W-1:0] tag;
        logic [PPN_W-1:0] ppn;
        logic [ASN_W-1:0] asn;
        perm_t            perm;
    } entry_t;

    typedef struct packed {
        logic [ENTRIES-1:0] vld;
        logic [ENTRIES-1:0] glb;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    entry_t           ent_d [ENTRIES];
    entry_t           ent_q [ENTRIES];

    logic [VPN_W-1:0] tag_v [ENTRIES];
    logic [ASN_W-1:0] asn_v [ENTRIES];

    logic [ENTRIES-1:0] lk_hits;
    logic [ENTRIES-1:0] fl_hits;
    logic               lk_any;
    logic [IDX_W-1:0]   lk_sel;
    logic               lk_many;

    logic [IDX_W-1:0] vic_ptr;
    logic             vic_adv;
    logic             vic_clr;
    tlb_op_e          op;

    logic [VPN_W-1:0] ins_vpn;
    logic [VPN_W-1:0] fl_vpn;
    entry_t           ins_ent;
    logic             unused_ofs;

    assign ins_vpn    = ins_va[VA_W-1:OFS_W];
    assign fl_vpn     = fl_va[VA_W-1:OFS_W];
    assign unused_ofs = ^{ins_va[OFS_W-1:0], fl_va[OFS_W-1:0]};

    for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
        assign tag_v[g] = ent_q[g].tag;
        assign asn_v[g] = ent_q[g].asn;
    end

    // lookup comparator bank
    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_lk_match (
        .vld_i     (ctl_q.vld),
        .glb_i     (ctl_q.glb),
        .tag_i     (tag_v),
        .asn_i     (asn_v),
        .key_vpn_i (lk_vpn),
        .key_asn_i (lk_asn),
        .hit_o     (lk_hits)
    );

    // selective-flush comparator bank, same match rule
    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_fl_match (
        .vld_i     (ctl_q.vld),
        .glb_i     (ctl_q.glb),
        .tag_i     (tag_v),
        .asn_i     (asn_v),
        .key_vpn_i (fl_vpn),
        .key_asn_i (fl_asn),
        .hit_o     (fl_hits)
    );

    tlb_first_hit #(.ENTRIES(ENTRIES)) u_pick (
        .hit_i   (lk_hits),
        .any_o   (lk_any),
        .idx_o   (lk_sel),
        .multi_o (lk_many)
    );

    tlb_victim #(.ENTRIES(ENTRIES)) u_vic (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (vic_adv),
        .clr_i (vic_clr),
        .ptr_o (vic_ptr)
    );

    assign op = resolve_op(fl_all, fl_nonglobal, fl_addr, ins_en);

    always_comb begin
        ins_ent.tag           = ins_vpn;
        ins_ent.ppn           = ins_ppn;
        ins_ent.asn           = ins_asn;
        ins_ent.perm.rd_en    = ins_rd_en;
        ins_ent.perm.wr_en    = ins_wr_en;
        ins_ent.perm.fault_rd = ins_fault_rd;
        ins_ent.perm.fault_wr = ins_fault_wr;
    end

    // next-state computation
    always_comb begin
        ctl_d   = ctl_q;
        vic_adv = 1'b0;
        vic_clr = 1'b0;
        for (int i = 0; i < ENTRIES; i++) ent_d[i] = ent_q[i];

        unique case (op)
            OP_CLR_ALL: begin
                ctl_d.vld = '0;
                vic_clr   = 1'b1;
            end
            OP_CLR_NONGLB: begin
                ctl_d.vld = ctl_q.vld & ctl_q.glb;
            end
            OP_CLR_ADDR: begin
                ctl_d.vld = ctl_q.vld & ~fl_hits;
            end
            OP_INSERT: begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (IDX_W'(i) == vic_ptr) begin
                        ent_d[i]     = ins_ent;
                        ctl_d.vld[i] = 1'b1;
                        ctl_d.glb[i] = ins_global;
                    end
                end
                vic_adv = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // payload needs no reset: every use is gated by a valid bit
    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) ent_q[i] <= ent_d[i];
    end

    // lookup outputs, forced to zero on a miss
    entry_t sel_ent;
    logic   sel_glb;

    always_comb begin
        sel_ent = '0;
        sel_glb = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_any && IDX_W'(i) == lk_sel) begin
                sel_ent = ent_q[i];
                sel_glb = ctl_q.glb[i];
            end
        end
    end

    assign lk_hit      = lk_any;
    assign lk_idx      = lk_sel;
    assign lk_multi    = lk_many;
    assign lk_ppn      = sel_ent.ppn;
    assign lk_ent_asn  = sel_ent.asn;
    assign lk_global   = sel_glb;
    assign lk_rd_en    = sel_ent.perm.rd_en;
    assign lk_wr_en    = sel_ent.perm.wr_en;
    assign lk_fault_rd = sel_ent.perm.fault_rd;
    assign lk_fault_wr = sel_ent.perm.fault_wr;

endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
    parameter int ENTRIES = 48,
    parameter int VA_W    = 43,
    parameter int OFS_W   = 13,
    parameter int ASN_W   = 8,
    localparam int VPN_W  = VA_W - OFS_W,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [VPN_W-1:0] lk_vpn,
    input logic [ASN_W-1:0] lk_asn,
    input logic             lk_hit,
    input logic             lk_multi,
    input logic [ASN_W-1:0] lk_ent_asn,
    input logic             lk_global,
    input logic             ins_en,
    input logic             fl_all,
    input logic             fl_nonglobal,
    input logic             fl_addr,
    input logic [VA_W-1:0]  fl_va,
    input logic [ASN_W-1:0] fl_asn,
    input logic [IDX_W-1:0] ptr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic any_fl;
    assign any_fl = fl_all || fl_nonglobal || fl_addr;

    // R1
    r1_asn_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && !lk_global) |-> (lk_ent_asn == lk_asn));

    // R2
    r2_ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= LAST);

    // R2
    r2_ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && !any_fl) |=>
            (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + IDX_W'(1))));

    // R4
    r4_flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_all |=> (!lk_hit && ptr == '0));

    // R5
    r5_keep_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_nonglobal && !fl_all) |=> (!lk_hit || lk_global));

    // R6
    r6_flush_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_addr && !fl_all && !fl_nonglobal) |=>
            !(lk_hit && lk_vpn == $past(fl_va[VA_W-1:OFS_W]) && lk_asn == $past(fl_asn)));

    // R7
    r7_multi_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_multi |-> lk_hit);

    // R8
    r8_flush_blocks_ins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && (fl_nonglobal || fl_addr) && !fl_all) |=> $stable(ptr));

endmodule

bind tlb_fa tlb_fa_chk #(
    .ENTRIES (ENTRIES),
    .VA_W    (VA_W),
    .OFS_W   (OFS_W),
    .ASN_W   (ASN_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_vpn       (lk_vpn),
    .lk_asn       (lk_asn),
    .lk_hit       (lk_hit),
    .lk_multi     (lk_multi),
    .lk_ent_asn   (lk_ent_asn),
    .lk_global    (lk_global),
    .ins_en       (ins_en),
    .fl_all       (fl_all),
    .fl_nonglobal (fl_nonglobal),
    .fl_addr      (fl_addr),
    .fl_va        (fl_va),
    .fl_asn       (fl_asn),
    .ptr          (vic_ptr)
);

// File: tb/tb_tlb_fa.sv
`timescale 1ns/1ps
module tb_tlb_fa;

    localparam int N     = 8;
    localparam int VA_W  = 43;
    localparam int OFS_W = 13;
    localparam int PPN_W = 27;
    localparam int ASN_W = 8;
    localparam int VPN_W = VA_W - OFS_W;
    localparam int IDX_W = $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [VPN_W-1:0] lk_vpn = '0;
    logic [ASN_W-1:0] lk_asn = '0;
    logic             lk_hit, lk_multi, lk_global, lk_fault_rd, lk_fault_wr;
    logic [IDX_W-1:0] lk_idx;
    logic [PPN_W-1:0] lk_ppn;
    logic [ASN_W-1:0] lk_ent_asn;
    logic [3:0]       lk_rd_en, lk_wr_en;
    logic             ins_en = 1'b0;
    logic [VA_W-1:0]  ins_va = '0;
    logic [PPN_W-1:0] ins_ppn = '0;
    logic [ASN_W-1:0] ins_asn = '0;
    logic             ins_global = 1'b0;
    logic [3:0]       ins_rd_en = '0, ins_wr_en = '0;
    logic             ins_fault_rd = 1'b0, ins_fault_wr = 1'b0;
    logic             fl_all = 1'b0, fl_nonglobal = 1'b0, fl_addr = 1'b0;
    logic [VA_W-1:0]  fl_va = '0;
    logic [ASN_W-1:0] fl_asn = '0;

    tlb_fa #(.ENTRIES(N), .VA_W(VA_W), .OFS_W(OFS_W), .PPN_W(PPN_W), .ASN_W(ASN_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(lk_vpn), .lk_asn(lk_asn), .lk_hit(lk_hit), .lk_idx(lk_idx),
        .lk_multi(lk_multi), .lk_ppn(lk_ppn), .lk_ent_asn(lk_ent_asn),
        .lk_global(lk_global), .lk_rd_en(lk_rd_en), .lk_wr_en(lk_wr_en),
        .lk_fault_rd(lk_fault_rd), .lk_fault_wr(lk_fault_wr),
        .ins_en(ins_en), .ins_va(ins_va), .ins_ppn(ins_ppn), .ins_asn(ins_asn),
        .ins_global(ins_global), .ins_rd_en(ins_rd_en), .ins_wr_en(ins_wr_en),
        .ins_fault_rd(ins_fault_rd), .ins_fault_wr(ins_fault_wr),
        .fl_all(fl_all), .fl_nonglobal(fl_nonglobal), .fl_addr(fl_addr),
        .fl_va(fl_va), .fl_asn(fl_asn)
    );

    // reference model built from the requirements
    logic             m_vld [N];
    logic             m_glb [N];
    logic [VPN_W-1:0] m_tag [N];
    logic [ASN_W-1:0] m_asn [N];
    logic [PPN_W-1:0] m_ppn [N];
    logic [9:0]       m_perm [N];
    int               m_ptr;

    typedef struct {
        logic             hit;
        int               idx;
        logic             multi;
        logic [PPN_W-1:0] ppn;
        logic [ASN_W-1:0] asn;
        logic             glb;
        logic [9:0]       perm;
        string            req;
    } exp_t;

    exp_t exp_q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 0;

    function automatic bit m_match(int i, logic [VPN_W-1:0] v, logic [ASN_W-1:0] a);
        return m_vld[i] && m_tag[i] == v && (m_glb[i] || m_asn[i] == a);
    endfunction

    // monitor: compares one expected item per clock after the edge settles
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                logic [9:0] got_perm;
                e = exp_q.pop_front();
                got_perm = {lk_rd_en, lk_wr_en, lk_fault_rd, lk_fault_wr};
                n_tests++;
                if (lk_hit !== e.hit || lk_multi !== e.multi ||
                    (e.hit && int'(lk_idx) != e.idx) ||
                    lk_ppn !== e.ppn || lk_ent_asn !== e.asn ||
                    lk_global !== e.glb || got_perm !== e.perm) begin
                    n_fail++;
                    $display("FAIL %s: got hit=%0b idx=%0d multi=%0b ppn=%h asn=%h g=%0b perm=%h, expected hit=%0b idx=%0d multi=%0b ppn=%h asn=%h g=%0b perm=%h",
                        e.req, lk_hit, lk_idx, lk_multi, lk_ppn, lk_ent_asn, lk_global, got_perm,
                        e.hit, e.idx, e.multi, e.ppn, e.asn, e.glb, e.perm);
                end
            end
        end
    end

    // driver: lookup with expectation derived from the model
    task automatic look(input logic [VPN_W-1:0] v, input logic [ASN_W-1:0] a, input string req);
        exp_t e;
        int   cnt = 0;
        @(negedge clk);
        lk_vpn = v;
        lk_asn = a;
        e.hit = 0; e.idx = 0; e.multi = 0; e.ppn = '0; e.asn = '0; e.glb = 0; e.perm = '0;
        e.req = req;
        for (int i = N - 1; i >= 0; i--) begin
            if (m_match(i, v, a)) begin
                cnt++;
                e.hit = 1; e.idx = i; e.ppn = m_ppn[i]; e.asn = m_asn[i];
                e.glb = m_glb[i]; e.perm = m_perm[i];
            end
        end
        e.multi = (cnt > 1);
        exp_q.push_back(e);
        @(posedge clk);
    endtask

    // driver: one command cycle (insert and/or flushes), then model update
    task automatic cmd(input logic ins, input logic fa, input logic fng, input logic fad,
                       input logic [VPN_W-1:0] v, input logic [ASN_W-1:0] a,
                       input logic g, input logic [PPN_W-1:0] p, input logic [9:0] perm);
        @(negedge clk);
        ins_en = ins; fl_all = fa; fl_nonglobal = fng; fl_addr = fad;
        ins_va = {v, 13'h0a5c}; ins_asn = a; ins_global = g; ins_ppn = p;
        {ins_rd_en, ins_wr_en, ins_fault_rd, ins_fault_wr} = perm;
        fl_va = {v, 13'h1f03}; fl_asn = a;
        @(posedge clk);
        if (fa) begin
            for (int i = 0; i < N; i++) m_vld[i] = 0;
            m_ptr = 0;
        end else if (fng) begin
            for (int i = 0; i < N; i++) if (!m_glb[i]) m_vld[i] = 0;
        end else if (fad) begin
            for (int i = 0; i < N; i++) if (m_match(i, v, a)) m_vld[i] = 0;
        end else if (ins) begin
            m_vld[m_ptr] = 1; m_glb[m_ptr] = g; m_tag[m_ptr] = v;
            m_asn[m_ptr] = a; m_ppn[m_ptr] = p; m_perm[m_ptr] = perm;
            m_ptr = (m_ptr == N - 1) ? 0 : m_ptr + 1;
        end
        @(negedge clk);
        ins_en = 0; fl_all = 0; fl_nonglobal = 0; fl_addr = 0;
    endtask

    task automatic ins(input logic [VPN_W-1:0] v, input logic [ASN_W-1:0] a,
                       input logic g, input logic [PPN_W-1:0] p, input logic [9:0] perm);
        cmd(1, 0, 0, 0, v, a, g, p, perm);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 0; m_glb[i] = 0; m_tag[i] = '0; m_asn[i] = '0;
            m_ppn[i] = '0; m_perm[i] = '0;
        end
        m_ptr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: empty after reset, outputs zero on miss
        look(30'h10, 8'd1, "R9 reset miss");
        look(30'h0, 8'd0, "R9 reset miss zero key");

        // R3: fields stored and returned; R1: address-space match rule
        ins(30'h10, 8'd1, 0, 27'h100, 10'b1010_0101_10);
        ins(30'h20, 8'd9, 1, 27'h200, 10'b1111_0001_01);
        ins(30'h30, 8'd2, 0, 27'h300, 10'b0001_1000_11);
        look(30'h10, 8'd1, "R3 fields entry0");
        look(30'h10, 8'd2, "R1 asn mismatch miss");
        look(30'h20, 8'd5, "R1 global any asn");
        look(30'h30, 8'd2, "R3 fields entry2");
        look(30'h31, 8'd2, "R1 tag mismatch miss");

        // R7: duplicate tag, lowest index wins with multi flag
        ins(30'h10, 8'd7, 1, 27'h111, 10'b0000_0000_00);
        look(30'h10, 8'd1, "R7 lowest index multi");
        look(30'h10, 8'd7, "R7 single hit no multi");

        // R6: selective flush removes both matching entries, spares others
        cmd(0, 0, 0, 1, 30'h10, 8'd1, 0, '0, '0);
        look(30'h10, 8'd1, "R6 flushed addr asn1");
        look(30'h10, 8'd7, "R6 global with tag also flushed");
        look(30'h30, 8'd2, "R6 other entry kept");

        // R5: non-global flush keeps global entries
        cmd(0, 0, 1, 0, '0, '0, 0, '0, '0);
        look(30'h30, 8'd2, "R5 nonglobal removed");
        look(30'h20, 8'd3, "R5 global kept");

        // R8: flush in same cycle as insert drops the insert
        cmd(1, 0, 0, 1, 30'h44, 8'd4, 0, 27'h444, 10'h3ff);
        look(30'h44, 8'd4, "R8 insert dropped by flush");
        ins(30'h45, 8'd4, 0, 27'h445, 10'h155);
        look(30'h45, 8'd4, "R8 pointer held at 4");

        // R2: fill past N to wrap and overwrite entry 0 and 1
        for (int k = 0; k < 5; k++) ins(30'h50 + 30'(k), 8'd3, 0, 27'h500 + 27'(k), 10'(k));
        look(30'h54, 8'd3, "R2 wrap overwrote entry1");
        look(30'h53, 8'd3, "R2 wrap wrote entry0");
        look(30'h20, 8'd3, "R2 overwritten global gone");
        look(30'h52, 8'd3, "R2 last slot");

        // R8: all beats nonglobal; R4: all cleared and pointer to 0
        ins(30'h60, 8'd3, 1, 27'h600, 10'h2aa);
        cmd(1, 1, 1, 0, 30'h61, 8'd3, 0, 27'h611, 10'h0);
        look(30'h60, 8'd3, "R4 global cleared by flush all");
        look(30'h45, 8'd4, "R4 nonglobal cleared");
        ins(30'h70, 8'd1, 0, 27'h700, 10'h0f0);
        look(30'h70, 8'd1, "R4 insert at entry0 after flush");

        repeat (3) @(posedge clk);
        #1;
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule